// File: doc/BRIEF.md
# Fault Impact Classifier with Self-Checking Verdicts

During a fault-injection campaign this block watches one injected fault at a time. For every applied input vector it is handed the fault-free output word, the output word of the faulty circuit, and the verdict of an external code checker on the faulty word. It remembers, per fault, whether any vector exposed the fault through the code checker and whether any vector produced a wrong word that still passed the checker.

When the fault is closed, the block sorts it into one of four impact classes and increments a per-class total. When the campaign is declared finished, the totals freeze. The block then reports whether the circuit under test is fault-secure, self-testing and totally self-checking. Fault insertion, vector generation and the code checker are outside the block.

Top module: `fault_class_eval`

## Requirements
- R1: A valid vector with `code_ok` low marks the current fault as detected, whether or not `golden` and `faulty` differ.
- R2: A valid vector with `code_ok` high and `golden` different from `faulty` marks the current fault as having produced an undetected wrong word.
- R3: A valid vector with matching words and `code_ok` high marks nothing. Data presented while `vec_valid` is low is ignored.
- R4: The cycle after `fault_last` is sampled, `class_valid` is high for one cycle. `class_code` then holds 0 (neither mark), 1 (detected only), 2 (undetected only) or 3 (both). A vector applied in the same cycle as `fault_last` is included.
- R5: `fault_start` and the closing of a fault both clear the per-fault marks. A fault closed with no valid vectors is code 0.
- R6: Each closed fault increments exactly one of `cnt_a`, `cnt_b`, `cnt_c`, `cnt_d`, chosen by its code 0 to 3.
- R7: The totals saturate at 2^CW-1 and never wrap.
- R8: Once `campaign_done` has been sampled high, `verdict_valid` stays high until reset. From then on `fault_last` changes no total and produces no `class_valid`.
- R9: While `verdict_valid` is high, the flags are defined as follows. `fs` is high iff `cnt_c` and `cnt_d` are zero. `st` is high iff `cnt_a` and `cnt_c` are zero. `tsc` is high iff both `fs` and `st` are high. All three flags are low while `verdict_valid` is low.
- R10: A synchronous active-high `rst` clears the marks, the totals, `class_valid`, `class_code` and `verdict_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fault_start | input | 1 | Opens a new fault, clearing its marks |
| vec_valid | input | 1 | A vector result is present |
| golden | input | W | Fault-free output word |
| faulty | input | W | Output word of the faulty circuit |
| code_ok | input | 1 | Code checker passed the faulty word |
| fault_last | input | 1 | Closes the current fault |
| campaign_done | input | 1 | Ends the campaign and freezes the totals |
| class_valid | output | 1 | One-cycle pulse with the class of the closed fault |
| class_code | output | 2 | Class of the closed fault (0..3) |
| cnt_a | output | CW | Faults of class 0 |
| cnt_b | output | CW | Faults of class 1 |
| cnt_c | output | CW | Faults of class 2 |
| cnt_d | output | CW | Faults of class 3 |
| verdict_valid | output | 1 | Campaign finished, verdicts meaningful |
| fs | output | 1 | Fault-secure verdict |
| st | output | 1 | Self-testing verdict |
| tsc | output | 1 | Totally-self-checking verdict |

## Verification
The properties take for granted that `rst` is held for at least one clock at start-up. They also assume that `golden`, `faulty` and `code_ok` mean something only when `vec_valid` is high, and that `fault_last` is a plain level sampled each clock with no handshake. The stimulus raises `fault_last` for exactly one cycle per fault in the classification runs. It then holds `fault_last` high for many cycles in a row only in the saturation run, where every cycle is a legitimate zero-vector fault. It also deliberately puts mismatching data on the word inputs while `vec_valid` is low, which checks that such data has no effect.

// File: rtl/fault_class_eval.sv
module fault_class_eval #(
  parameter int W  = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fault_start,
  input  logic          vec_valid,
  input  logic [W-1:0]  golden,
  input  logic [W-1:0]  faulty,
  input  logic          code_ok,
  input  logic          fault_last,
  input  logic          campaign_done,
  output logic          class_valid,
  output logic [1:0]    class_code,
  output logic [CW-1:0] cnt_a,
  output logic [CW-1:0] cnt_b,
  output logic [CW-1:0] cnt_c,
  output logic [CW-1:0] cnt_d,
  output logic          verdict_valid,
  output logic          fs,
  output logic          st,
  output logic          tsc
);
  localparam int NCLS = 4;
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic seen_test, seen_err, done_q;
  logic [CW-1:0] cnt [NCLS];

  wire hit_test = vec_valid & ~code_ok;
  wire hit_err  = vec_valid & code_ok & (golden != faulty);
  wire cur_test = (seen_test & ~fault_start) | hit_test;
  wire cur_err  = (seen_err  & ~fault_start) | hit_err;
  wire [1:0] cls = {cur_err, cur_test};
  wire close = fault_last & ~done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_test   <= 1'b0;
      seen_err    <= 1'b0;
      class_valid <= 1'b0;
      class_code  <= 2'd0;
      done_q      <= 1'b0;
    end else begin
      seen_test   <= cur_test & ~close;
      seen_err    <= cur_err  & ~close;
      class_valid <= close;
      if (close) class_code <= cls;
      done_q      <= done_q | campaign_done;
    end
  end

  for (genvar i = 0; i < NCLS; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)
        cnt[i] <= '0;
      else if (close && cls == 2'(i) && cnt[i] != CNT_MAX)
        cnt[i] <= cnt[i] + 1'b1;
    end
  end

  assign cnt_a = cnt[0];
  assign cnt_b = cnt[1];
  assign cnt_c = cnt[2];
  assign cnt_d = cnt[3];

  assign verdict_valid = done_q;
  assign fs  = done_q & (cnt[2] == '0) & (cnt[3] == '0);
  assign st  = done_q & (cnt[0] == '0) & (cnt[2] == '0);
  assign tsc = fs & st;
endmodule

// File: rtl/fault_class_eval_chk.sv
module fault_class_eval_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          fault_last,
  input logic          class_valid,
  input logic          verdict_valid,
  input logic [CW-1:0] cnt_a,
  input logic [CW-1:0] cnt_b,
  input logic [CW-1:0] cnt_c,
  input logic [CW-1:0] cnt_d,
  input logic          fs,
  input logic          st,
  input logic          tsc
);
  a_r4_pulse_follows: assert property (@(posedge clk) disable iff (rst)
    (fault_last && !verdict_valid) |=> class_valid);

  a_r4_pulse_cause: assert property (@(posedge clk) disable iff (rst)
    class_valid |-> $past(fault_last));

  a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt_a == {CW{1'b1}}) |=> (cnt_a == {CW{1'b1}}));

  a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
    verdict_valid |=> ($stable(cnt_a) && $stable(cnt_b) && $stable(cnt_c)
                       && $stable(cnt_d) && !class_valid && verdict_valid));

  a_r9_tsc_needs_both: assert property (@(posedge clk) disable iff (rst)
    tsc |-> (fs && st));

  a_r9_idle_low: assert property (@(posedge clk) disable iff (rst)
    !verdict_valid |-> (!fs && !st && !tsc));
endmodule

bind fault_class_eval fault_class_eval_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .fault_last(fault_last), .class_valid(class_valid),
  .verdict_valid(verdict_valid), .cnt_a(cnt_a), .cnt_b(cnt_b),
  .cnt_c(cnt_c), .cnt_d(cnt_d), .fs(fs), .st(st), .tsc(tsc)
);

// File: tb/fault_class_eval_tb.sv
module fault_class_eval_tb;
  localparam int W = 8;
  localparam int CW = 16;
  localparam int N = 8;
  // [39]v0 [38]ok0 [37]v1 [36]ok1 [35:34]exp [31:24]g0 [23:16]f0 [15:8]g1 [7:0]f1
  localparam logic [39:0] TAB [N] = '{
    40'hF0_5555_1212,  // R3 clean -> 0
    40'hB4_AAAB_1212,  // R1 mismatch + code fail -> 1
    40'h94_0F0F_0000,  // R1 match + code fail -> 1
    40'hF8_3331_4444,  // R2 -> 2
    40'hEC_3331_0080,  // R2 and R1 -> 3
    40'h50_1234_5678,  // R3/R5 invalid data only -> 0
    40'h64_1122_5AA5,  // R3 invalid, then R1 -> 1
    40'hBC_0102_1020   // R1 then R2 -> 3
  };

  logic clk = 0, rst = 1;
  logic fault_start = 0, vec_valid = 0, code_ok = 1, fault_last = 0, campaign_done = 0;
  logic [W-1:0] golden = '0, faulty = '0;
  logic class_valid, verdict_valid, fs, st, tsc;
  logic [1:0] class_code;
  logic [CW-1:0] cnt_a, cnt_b, cnt_c, cnt_d;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fault_class_eval #(.W(W), .CW(CW)) u_dut (
    .clk(clk), .rst(rst), .fault_start(fault_start), .vec_valid(vec_valid),
    .golden(golden), .faulty(faulty), .code_ok(code_ok), .fault_last(fault_last),
    .campaign_done(campaign_done), .class_valid(class_valid), .class_code(class_code),
    .cnt_a(cnt_a), .cnt_b(cnt_b), .cnt_c(cnt_c), .cnt_d(cnt_d),
    .verdict_valid(verdict_valid), .fs(fs), .st(st), .tsc(tsc));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; fault_start = 0; vec_valid = 0; fault_last = 0; campaign_done = 0; code_ok = 1;
    @(negedge clk);
    rst = 0;
  endtask

  task automatic run_fault(input logic [39:0] e, input string req);
    @(negedge clk);
    fault_start = 1;
    @(negedge clk);
    fault_start = 0;
    vec_valid = e[39]; code_ok = e[38]; golden = e[31:24]; faulty = e[23:16];
    @(negedge clk);
    vec_valid = e[37]; code_ok = e[36]; golden = e[15:8]; faulty = e[7:0];
    fault_last = 1;
    @(negedge clk);
    fault_last = 0; vec_valid = 0; code_ok = 1;
    chk({req, " R4 class_valid"}, 32'(class_valid), 1);
    chk({req, " R4 class_code"}, 32'(class_code), 32'(e[35:34]));
  endtask

  task automatic finish_campaign();
    @(negedge clk);
    campaign_done = 1;
    @(negedge clk);
    campaign_done = 0;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    repeat (40000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R10 reset state, R9 flags low before done
    chk("R10 cnt_a", 32'(cnt_a), 0);
    chk("R10 class_valid", 32'(class_valid), 0);
    chk("R10 verdict_valid", 32'(verdict_valid), 0);
    chk("R9 fs low before done", 32'({fs, st, tsc}), 0);

    for (int i = 0; i < N; i++) run_fault(TAB[i], $sformatf("table%0d R1 R2 R3", i));

    // R4 pulse lasts one cycle
    @(negedge clk);
    chk("R4 one-cycle pulse", 32'(class_valid), 0);

    // R6 totals
    chk("R6 cnt_a", 32'(cnt_a), 2);
    chk("R6 cnt_b", 32'(cnt_b), 3);
    chk("R6 cnt_c", 32'(cnt_c), 1);
    chk("R6 cnt_d", 32'(cnt_d), 2);

    // R5 fault_start clears a pending mark
    @(negedge clk);
    vec_valid = 1; code_ok = 1; golden = 8'h01; faulty = 8'h02;
    @(negedge clk);
    vec_valid = 0; fault_start = 1;
    @(negedge clk);
    fault_start = 0; fault_last = 1;
    @(negedge clk);
    fault_last = 0;
    chk("R5 cleared by start", 32'(class_code), 0);
    chk("R5 cnt_a", 32'(cnt_a), 3);
    chk("R5 cnt_c unchanged", 32'(cnt_c), 1);

    // R8 and R9 with A, C and D present
    finish_campaign();
    chk("R8 verdict_valid", 32'(verdict_valid), 1);
    chk("R9 fs", 32'(fs), 0);
    chk("R9 st", 32'(st), 0);
    chk("R9 tsc", 32'(tsc), 0);
    @(negedge clk);
    vec_valid = 1; code_ok = 0; fault_last = 1;
    @(negedge clk);
    vec_valid = 0; code_ok = 1; fault_last = 0;
    chk("R8 no pulse after done", 32'(class_valid), 0);
    chk("R8 cnt_b frozen", 32'(cnt_b), 3);
    chk("R8 cnt_a frozen", 32'(cnt_a), 3);

    // R10 reset clears
    do_reset();
    chk("R10 cnt_b cleared", 32'(cnt_b), 0);
    chk("R10 cnt_d cleared", 32'(cnt_d), 0);
    chk("R10 verdict cleared", 32'(verdict_valid), 0);

    // R9 only class 1 -> all verdicts high
    run_fault(TAB[1], "R9 b-only");
    run_fault(TAB[2], "R9 b-only");
    finish_campaign();
    chk("R9 fs b-only", 32'(fs), 1);
    chk("R9 st b-only", 32'(st), 1);
    chk("R9 tsc b-only", 32'(tsc), 1);

    // R9 classes 0 and 1 -> fs only
    do_reset();
    run_fault(TAB[0], "R9 a+b");
    run_fault(TAB[1], "R9 a+b");
    finish_campaign();
    chk("R9 fs a+b", 32'(fs), 1);
    chk("R9 st a+b", 32'(st), 0);
    chk("R9 tsc a+b", 32'(tsc), 0);

    // R9 classes 1 and 3 -> st only
    do_reset();
    run_fault(TAB[1], "R9 b+d");
    run_fault(TAB[7], "R9 b+d");
    finish_campaign();
    chk("R9 fs b+d", 32'(fs), 0);
    chk("R9 st b+d", 32'(st), 1);
    chk("R9 tsc b+d", 32'(tsc), 0);

    // R7 saturation with back-to-back zero-vector faults
    do_reset();
    @(negedge clk);
    fault_last = 1;
    repeat (65540) @(negedge clk);
    fault_last = 0;
    @(negedge clk);
    chk("R7 cnt_a saturated", 32'(cnt_a), 65535);
    chk("R7 cnt_b untouched", 32'(cnt_b), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule